// File: doc/BRIEF.md
# Two-Die Fault Supervisor

This block watches over a gate driver built from two dies: a control die and an output die, which talk to each other through a periodic heartbeat. It checks the parity of each configuration register image on both dies. It counts cycles since the last heartbeat edge from the output die. It also tracks whether each die's oscillator started after power-on and whether it is still running. From these inputs it makes a small set of reactions. Each die can be held in reset, either while the cause lasts or until the next power-on reset. A one-cycle switch-off request goes to the output stage. A ready line comes from the control die. A status bit reports whether the output die is usable. Sticky error bits record what happened, and a fault line stays high while any of those bits is set.

Software clears error bits with a write-one-to-clear strobe and a mask. A clear only takes effect once the matching cause has gone away. Register access, the analog stage and the oscillators themselves are outside this block. Oscillator health arrives as a level per die, and the switch-off sequence is started by a single pulse.

Top module: `twin_die_guard`

## Requirements
- R1: Each register image holds NUM_REGS fields of REG_W+1 bits. Field k sits at bits [k*(REG_W+1) +: REG_W+1], and its top bit is that field's parity bit. A field is good when the XOR of all its bits is 0. Any bad field is a memory failure for the die that owns the image. Flipping an even number of bits inside one field is therefore not detected.
- R2: During a control-die memory failure, ctlHold is 1, ready is 0, errStat[0] is 1 and fault is 1 from the first cycle after the failure appears.
- R3: During an output-die memory failure, outHold is 1 and errStat[1] is 1 from the first cycle after the failure appears. outHold drops on the first cycle after the parity is good again.
- R4: offReq is a one-cycle pulse. It fires on the cycle after any cause first appears. The causes are: control memory failure, output memory failure, lifesign loss, output oscillator loss during operation, output oscillator start failure and control oscillator start failure. It does not repeat while that cause persists.
- R5: Once the output oscillator has started, LIFE_WIN cycles with no level change on heartbeat set errStat[2]. A heartbeat that changes level more often than that never sets it.
- R6: If the output oscillator drops after having started, outRdy goes to 0 and errStat[3] is set, while outHold stays 0. outRdy returns to 1 on the first cycle after the oscillator recovers.
- R7: If outOscOk is not seen high within START_WIN cycles after reset, outHold and errStat[3] stay 1 and outRdy stays 0 until the next power-on reset, even if the oscillator starts later. ready stays 1.
- R8: If ctlOscOk is not seen high within START_WIN cycles after reset, ctlHold stays 1 and ready stays 0 until the next power-on reset, even if the oscillator starts later.
- R9: The errStat bits are sticky: bit 0 control memory, bit 1 output memory, bit 2 lifesign loss, bit 3 output oscillator. A bit clears on the cycle after clrStb is high with its clrMask bit set, but only if its cause is inactive at that time. A clear while the cause is active has no effect.
- R10: fault is 1 exactly while some errStat bit is 1.
- R11: After reset, with both oscillators running and good parity: ctlHold=0, outHold=0, ready=1, offReq=0, errStat=0, fault=0 and outRdy=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| ctlRegs | input | NUM_REGS*(REG_W+1) | Control-die register image with parity bits |
| outRegs | input | NUM_REGS*(REG_W+1) | Output-die register image with parity bits |
| heartbeat | input | 1 | Lifesign level from the output die, expected to toggle |
| ctlOscOk | input | 1 | Control-die oscillator running |
| outOscOk | input | 1 | Output-die oscillator running |
| clrStb | input | 1 | Write-one-to-clear strobe for error bits |
| clrMask | input | 4 | Error bits selected by the clear strobe |
| ctlHold | output | 1 | Control die held in reset |
| outHold | output | 1 | Output die held in reset |
| ready | output | 1 | Control die ready (low while held) |
| fault | output | 1 | Fault flag, high while any error bit is set |
| offReq | output | 1 | One-cycle emergency switch-off request |
| outRdy | output | 1 | Output die usable status bit |
| errStat | output | 4 | Sticky error bits |

## Verification
A wrong cause register or a wrong edge-detect register would show at offReq. The pulse would be missing, repeated, or would appear one cycle off after a parity flip or an oscillator drop. This is visible within two cycles of the stimulus. A lifesign counter that does not reset or does not saturate would show as errStat[2] set while the heartbeat is still toggling, or never set, within about LIFE_WIN cycles. A startup latch that fails to hold would show as ctlHold or outHold dropping once the late oscillator comes up, a few cycles after that input rises.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  localparam int ERR_BITS  = 4;
  localparam int E_CTL_MEM = 0;
  localparam int E_OUT_MEM = 1;
  localparam int E_LIFE    = 2;
  localparam int E_OUT_OSC = 3;

  localparam int CAUSES    = 6;

  typedef struct packed {
    logic [ERR_BITS-1:0] errSet;
    logic [ERR_BITS-1:0] errClr;
  } errStrobe_t;
endpackage

// File: rtl/tdg_parity_bank.sv
module tdg_parity_bank #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8
) (
  input  logic [NUM_REGS*(REG_W+1)-1:0] regImg,
  output logic                          anyBad
);
  localparam int FW = REG_W + 1;

  logic [NUM_REGS-1:0] badVec;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_field
    assign badVec[k] = ^regImg[k*FW +: FW];
  end

  assign anyBad = |badVec;
endmodule

// File: rtl/tdg_datapath.sv
module tdg_datapath
  import tdg_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int REG_W     = 8,
  parameter int LIFE_WIN  = 16,
  parameter int START_WIN = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_REGS*(REG_W+1)-1:0] ctlRegs,
  input  logic [NUM_REGS*(REG_W+1)-1:0] outRegs,
  input  logic                          heartbeat,
  input  logic                          lifeArmed,
  input  errStrobe_t                    stb,
  output logic                          ctlParBad,
  output logic                          outParBad,
  output logic                          lifeLost,
  output logic                          windowDone,
  output logic [ERR_BITS-1:0]           errStat
);
  localparam int LIFE_CW  = $clog2(LIFE_WIN + 1);
  localparam int START_CW = $clog2(START_WIN + 1);
  localparam logic [LIFE_CW-1:0]  LIFE_MAX  = LIFE_CW'(LIFE_WIN);
  localparam logic [START_CW-1:0] START_MAX = START_CW'(START_WIN);

  tdg_parity_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_ctlPar (
    .regImg (ctlRegs),
    .anyBad (ctlParBad)
  );

  tdg_parity_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_outPar (
    .regImg (outRegs),
    .anyBad (outParBad)
  );

  // heartbeat edge detection and silence counter
  logic               hbPrev;
  logic [LIFE_CW-1:0] lifeCnt;
  logic               hbEdge;

  assign hbEdge = heartbeat ^ hbPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hbPrev  <= 1'b0;
      lifeCnt <= '0;
    end else begin
      hbPrev <= heartbeat;
      if (!lifeArmed || hbEdge) begin
        lifeCnt <= '0;
      end else if (lifeCnt != LIFE_MAX) begin
        lifeCnt <= lifeCnt + 1'b1;
      end
    end
  end

  assign lifeLost = lifeArmed && (lifeCnt == LIFE_MAX);

  // power-up observation window
  logic [START_CW-1:0] startCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCnt <= '0;
    end else if (startCnt != START_MAX) begin
      startCnt <= startCnt + 1'b1;
    end
  end

  assign windowDone = (startCnt == START_MAX);

  // sticky error bits, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errStat <= '0;
    end else begin
      errStat <= (errStat & ~stb.errClr) | stb.errSet;
    end
  end
endmodule

// File: rtl/tdg_control.sv
module tdg_control
  import tdg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctlParBad,
  input  logic                outParBad,
  input  logic                lifeLost,
  input  logic                windowDone,
  input  logic                ctlOscOk,
  input  logic                outOscOk,
  input  logic                clrStb,
  input  logic [ERR_BITS-1:0] clrMask,
  output logic                ctlHold,
  output logic                outHold,
  output logic                offReq,
  output logic                outRdy,
  output logic                lifeArmed,
  output errStrobe_t          stb
);
  logic ctlStarted, outStarted;
  logic ctlStartFail, outStartFail;
  logic [CAUSES-1:0] cause, causePrev;
  logic [ERR_BITS-1:0] errCause;
  logic outOscRun;

  assign outOscRun = outStarted && !outOscOk;

  always_comb begin
    cause    = '0;
    cause[0] = ctlParBad;
    cause[1] = outParBad;
    cause[2] = lifeLost;
    cause[3] = outOscRun;
    cause[4] = outStartFail;
    cause[5] = ctlStartFail;
  end

  always_comb begin
    errCause            = '0;
    errCause[E_CTL_MEM] = ctlParBad;
    errCause[E_OUT_MEM] = outParBad;
    errCause[E_LIFE]    = lifeLost;
    errCause[E_OUT_OSC] = outOscRun || outStartFail;
  end

  assign stb.errSet = errCause;
  assign stb.errClr = {ERR_BITS{clrStb}} & clrMask & ~errCause;

  assign lifeArmed = outStarted && !outStartFail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlStarted   <= 1'b0;
      outStarted   <= 1'b0;
      ctlStartFail <= 1'b0;
      outStartFail <= 1'b0;
    end else begin
      ctlStarted   <= ctlStarted || ctlOscOk;
      outStarted   <= outStarted || outOscOk;
      ctlStartFail <= ctlStartFail || (windowDone && !ctlStarted);
      outStartFail <= outStartFail || (windowDone && !outStarted);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causePrev <= '0;
      offReq    <= 1'b0;
      ctlHold   <= 1'b0;
      outHold   <= 1'b0;
      outRdy    <= 1'b0;
    end else begin
      causePrev <= cause;
      offReq    <= |(cause & ~causePrev);
      ctlHold   <= ctlParBad || ctlStartFail;
      outHold   <= outParBad || outStartFail;
      outRdy    <= outStarted && outOscOk && !outParBad && !outStartFail;
    end
  end
endmodule

// File: rtl/twin_die_guard.sv
module twin_die_guard
  import tdg_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int REG_W     = 8,
  parameter int LIFE_WIN  = 16,
  parameter int START_WIN = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_REGS*(REG_W+1)-1:0] ctlRegs,
  input  logic [NUM_REGS*(REG_W+1)-1:0] outRegs,
  input  logic                          heartbeat,
  input  logic                          ctlOscOk,
  input  logic                          outOscOk,
  input  logic                          clrStb,
  input  logic [3:0]                    clrMask,
  output logic                          ctlHold,
  output logic                          outHold,
  output logic                          ready,
  output logic                          fault,
  output logic                          offReq,
  output logic                          outRdy,
  output logic [3:0]                    errStat
);
  logic       ctlParBad, outParBad, lifeLost, windowDone, lifeArmed;
  errStrobe_t stb;

  tdg_datapath #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .LIFE_WIN (LIFE_WIN),
    .START_WIN(START_WIN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctlRegs    (ctlRegs),
    .outRegs    (outRegs),
    .heartbeat  (heartbeat),
    .lifeArmed  (lifeArmed),
    .stb        (stb),
    .ctlParBad  (ctlParBad),
    .outParBad  (outParBad),
    .lifeLost   (lifeLost),
    .windowDone (windowDone),
    .errStat    (errStat)
  );

  tdg_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .ctlParBad  (ctlParBad),
    .outParBad  (outParBad),
    .lifeLost   (lifeLost),
    .windowDone (windowDone),
    .ctlOscOk   (ctlOscOk),
    .outOscOk   (outOscOk),
    .clrStb     (clrStb),
    .clrMask    (clrMask),
    .ctlHold    (ctlHold),
    .outHold    (outHold),
    .offReq     (offReq),
    .outRdy     (outRdy),
    .lifeArmed  (lifeArmed),
    .stb        (stb)
  );

  assign ready = !ctlHold;
  assign fault = |errStat;
endmodule

// File: rtl/twin_die_guard_chk.sv
module twin_die_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctlParBad,
  input logic       outParBad,
  input logic       lifeLost,
  input logic       ctlHold,
  input logic       ready,
  input logic       outHold,
  input logic       offReq,
  input logic       clrStb,
  input logic [3:0] clrMask,
  input logic [3:0] errStat
);
  // R2: control parity error leads to hold, ready low and bit 0
  a_r2_ctl_mem_reaction: assert property (@(posedge clk) disable iff (!rstN)
    ctlParBad |=> (ctlHold && !ready && errStat[0]));

  // R3: output parity error leads to output hold and bit 1
  a_r3_out_mem_reaction: assert property (@(posedge clk) disable iff (!rstN)
    outParBad |=> (outHold && errStat[1]));

  // R4: switch-off request lasts a single cycle
  a_r4_off_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    offReq |=> !offReq);

  // R5: silent heartbeat window sets the lifesign bit
  a_r5_life_sets_bit: assert property (@(posedge clk) disable iff (!rstN)
    lifeLost |=> errStat[2]);

  // R9: an error bit only falls after a matching clear strobe
  a_r9_clear_only_by_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(errStat) & ~errStat) & ~({4{$past(clrStb)}} & $past(clrMask))) == 4'b0000));
endmodule

bind twin_die_guard twin_die_guard_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctlParBad (ctlParBad),
  .outParBad (outParBad),
  .lifeLost  (lifeLost),
  .ctlHold   (ctlHold),
  .ready     (ready),
  .outHold   (outHold),
  .offReq    (offReq),
  .clrStb    (clrStb),
  .clrMask   (clrMask),
  .errStat   (errStat)
);

// File: tb/sim_twin_die_guard.sv
`timescale 1ns/1ps
module sim_twin_die_guard;
  localparam int NUM_REGS  = 4;
  localparam int REG_W     = 8;
  localparam int FW        = REG_W + 1;
  localparam int LIFE_WIN  = 16;
  localparam int START_WIN = 32;

  // observed bundle: [9]ctlHold [8]outHold [7]ready [6]fault [5]offReq [4]outRdy [3:0]errStat
  localparam logic [9:0] M_CTL = 10'b1000000000;
  localparam logic [9:0] M_OUT = 10'b0100000000;
  localparam logic [9:0] M_RDY = 10'b0010000000;
  localparam logic [9:0] M_FLT = 10'b0001000000;
  localparam logic [9:0] M_OFF = 10'b0000100000;
  localparam logic [9:0] M_ORD = 10'b0000010000;
  localparam logic [9:0] M_E0  = 10'b0000000001;
  localparam logic [9:0] M_E1  = 10'b0000000010;
  localparam logic [9:0] M_E2  = 10'b0000000100;
  localparam logic [9:0] M_E3  = 10'b0000001000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_REGS*FW-1:0] ctlRegs = '0;
  logic [NUM_REGS*FW-1:0] outRegs = '0;
  logic heartbeat = 1'b0;
  logic ctlOscOk = 1'b1;
  logic outOscOk = 1'b1;
  logic clrStb = 1'b0;
  logic [3:0] clrMask = '0;
  logic ctlHold, outHold, ready, fault, offReq, outRdy;
  logic [3:0] errStat;

  logic hbEn = 1'b1;
  int total = 0;
  int bad = 0;
  int offCnt = 0;
  bit finished = 1'b0;

  typedef struct {
    string      tag;
    logic [9:0] mask;
    logic [9:0] val;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  twin_die_guard #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .LIFE_WIN(LIFE_WIN), .START_WIN(START_WIN)
  ) u0 (
    .clk(clk), .rstN(rstN), .ctlRegs(ctlRegs), .outRegs(outRegs),
    .heartbeat(heartbeat), .ctlOscOk(ctlOscOk), .outOscOk(outOscOk),
    .clrStb(clrStb), .clrMask(clrMask),
    .ctlHold(ctlHold), .outHold(outHold), .ready(ready), .fault(fault),
    .offReq(offReq), .outRdy(outRdy), .errStat(errStat)
  );

  // output die model: heartbeat stops while that die is held or disabled
  initial begin
    forever begin
      repeat (4) @(negedge clk);
      if (hbEn && !outHold) heartbeat = ~heartbeat;
    end
  end

  // monitor: sample after the edge, pop pending expectations
  always @(posedge clk) begin
    logic [9:0] obs;
    #2;
    obs = {ctlHold, outHold, ready, fault, offReq, outRdy, errStat};
    if (rstN && offReq) offCnt++;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if ((obs & it.mask) !== (it.val & it.mask)) begin
        bad++;
        $display("FAIL %s act=%b exp=%b mask=%b", it.tag, obs & it.mask, it.val & it.mask, it.mask);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectNext(input string tag, input logic [9:0] m, input logic [9:0] v);
    item_t it;
    it.tag = tag; it.mask = m; it.val = v;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic cOk, input logic oOk);
    @(negedge clk);
    rstN = 1'b0;
    ctlRegs = '0; outRegs = '0; clrStb = 1'b0; clrMask = '0;
    hbEn = 1'b1; ctlOscOk = cOk; outOscOk = oOk;
    tick(3);
    rstN = 1'b1;
    tick(3);
  endtask

  task automatic clearBits(input logic [3:0] m);
    clrStb = 1'b1; clrMask = m;
    @(negedge clk);
    clrStb = 1'b0; clrMask = '0;
  endtask

  initial begin
    int base;
    doReset(1'b1, 1'b1);
    // R11 reset state
    expectNext("R11 reset state", 10'h3FF, 10'b0010010000);

    // R1 R2 data bit error in field 2 of the control image
    base = offCnt;
    ctlRegs[2*FW + 0] = 1'b1;
    expectNext("R2 ctl mem reaction", M_CTL|M_RDY|M_FLT|M_OFF|M_E0, M_CTL|M_FLT|M_OFF|M_E0);
    expectNext("R4 no repeat pulse", M_CTL|M_OFF, M_CTL);
    tick(5);
    chkEq("R4 single pulse ctl mem", offCnt - base, 1);
    // R9 clear while cause active is ignored
    clrStb = 1'b1; clrMask = 4'b0001;
    @(negedge clk);
    clrStb = 1'b0; clrMask = '0;
    expectNext("R9 clear blocked while active", M_E0|M_FLT, M_E0|M_FLT);
    // R2 release, bit remains sticky
    ctlRegs = '0;
    expectNext("R2 hold released, R9 sticky", M_CTL|M_RDY|M_E0|M_FLT, M_RDY|M_E0|M_FLT);
    clrStb = 1'b1; clrMask = 4'b0001;
    expectNext("R9 R10 clear accepted", M_E0|M_FLT, 10'b0);
    clrStb = 1'b0; clrMask = '0;

    // R1 even flips in one field are not detected
    ctlRegs[1*FW + 0] = 1'b1; ctlRegs[1*FW + 1] = 1'b1;
    outRegs[3*FW + 0] = 1'b1; outRegs[3*FW + REG_W] = 1'b1;
    expectNext("R1 even flips pass", M_CTL|M_OUT|M_E0|M_E1|M_OFF, 10'b0);
    ctlRegs = '0; outRegs = '0;
    // R1 parity bit alone flags field 0
    ctlRegs[REG_W] = 1'b1;
    expectNext("R1 parity bit flip", M_CTL|M_E0, M_CTL|M_E0);
    ctlRegs = '0;
    tick(1);
    clearBits(4'b0001);
    expectNext("R10 fault clear after R1", M_FLT|M_E0, 10'b0);

    // R3 output memory failure, heartbeat stops -> R5 lifesign loss
    base = offCnt;
    outRegs[3*FW + 4] = 1'b1;
    expectNext("R3 out mem reaction", M_OUT|M_E1|M_FLT|M_OFF|M_ORD|M_RDY, M_OUT|M_E1|M_FLT|M_OFF|M_RDY);
    tick(LIFE_WIN + 8);
    expectNext("R5 lifesign lost under out hold", M_OUT|M_E2, M_OUT|M_E2);
    chkEq("R4 pulses out mem plus lifesign", offCnt - base, 2);
    outRegs = '0;
    expectNext("R3 out hold released", M_OUT|M_ORD, M_ORD);
    tick(8);
    clearBits(4'b0110);
    expectNext("R9 clear out mem and lifesign", M_E1|M_E2|M_FLT, 10'b0);

    // R5 steady heartbeat never trips
    base = offCnt;
    tick(3 * LIFE_WIN);
    expectNext("R5 no loss while toggling", M_E2|M_FLT, 10'b0);
    chkEq("R5 no pulse while toggling", offCnt - base, 0);
    // R5 silence
    hbEn = 1'b0;
    tick(LIFE_WIN - 6);
    expectNext("R5 not yet lost", M_E2, 10'b0);
    tick(12);
    expectNext("R5 lost after window", M_E2|M_FLT, M_E2|M_FLT);
    hbEn = 1'b1;
    tick(8);
    clearBits(4'b0100);
    expectNext("R9 lifesign cleared", M_E2|M_FLT, 10'b0);

    // R6 output oscillator drop during operation
    base = offCnt;
    outOscOk = 1'b0;
    expectNext("R6 osc drop", M_ORD|M_E3|M_FLT|M_OFF|M_OUT, M_E3|M_FLT|M_OFF);
    tick(4);
    outOscOk = 1'b1;
    expectNext("R6 osc recovered", M_ORD|M_E3, M_ORD|M_E3);
    clearBits(4'b1000);
    expectNext("R9 osc bit cleared", M_E3|M_FLT, 10'b0);
    chkEq("R4 pulse osc drop", offCnt - base, 1);

    // R7 output oscillator never starts
    doReset(1'b1, 1'b0);
    base = offCnt;
    tick(START_WIN + 5);
    expectNext("R7 out start fail", M_OUT|M_ORD|M_E3|M_FLT|M_RDY|M_CTL|M_E2,
               M_OUT|M_E3|M_FLT|M_RDY);
    chkEq("R4 pulse out start fail", offCnt - base, 1);
    clearBits(4'b1000);
    expectNext("R7 R9 clear ignored", M_E3, M_E3);
    outOscOk = 1'b1;
    tick(4);
    expectNext("R7 hold is permanent", M_OUT|M_ORD, M_OUT);

    // R8 control oscillator never starts
    doReset(1'b0, 1'b1);
    base = offCnt;
    tick(START_WIN + 5);
    expectNext("R8 ctl start fail", M_CTL|M_RDY|M_OUT|M_FLT, M_CTL);
    chkEq("R4 pulse ctl start fail", offCnt - base, 1);
    ctlOscOk = 1'b1;
    tick(5);
    expectNext("R8 hold is permanent", M_CTL|M_RDY, M_CTL);
    doReset(1'b1, 1'b1);
    expectNext("R8 R11 cleared by power-on reset", 10'h3FF, 10'b0010010000);

    tick(2);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule